// File: doc/BRIEF.md
# Streaming Hash Anti-Join

This block filters one table against another. A first table of keyed rows arrives on a single input stream and each key is filed into an on-chip hash table. A second table then arrives on the same stream, and the block forwards only those rows whose key was never seen in the first table. Rows whose key is present are silently discarded. The first table's payload plays no part in the result, so only its keys are retained.

Every bucket has two storage areas. The first is a fixed-depth area of base slots. The second is a shared pool of overflow entries, linked into one chain per bucket. Each area has its own per-bucket occupancy counter, and the counters live in separate memories. When the second table's last row has been resolved, the block pulses a completion flag. It then wipes its counters and is ready to accept a fresh first table.

Top module: `hash_antijoin`

## Requirements
- R1: During the probe phase, a row is emitted on the output, with its key and payload unchanged, exactly when its key differs from every key stored in the build phase. Emitted rows keep their input order.
- R2: The bucket index is the XOR of all BKT_BITS-wide slices of the key, with the key zero-extended to a whole number of slices. For the defaults this is key[7:0]^key[15:8]^key[23:16]^key[31:24].
- R3: A bucket holds up to BASE_DEPTH keys in base slots. Later keys for that bucket are placed in the shared overflow pool. A key stored in either area suppresses matching probe rows.
- R4: When a build row finds its bucket's base slots full and all OVF_DEPTH overflow entries already allocated, the row is dropped and ovf_err rises. ovf_err stays high until the completion pulse. A dropped key behaves as absent during the probe.
- R5: The first row accepted after reset, or after completion, begins the build phase, and the row flagged in_last ends it. The following rows form the probe phase. No output is produced during the build phase.
- R6: out_last is high on an emitted row only when that row is the final probe row. If the final probe row matches, no output row carries out_last.
- R7: done is high for exactly one cycle once the final probe row is resolved. Afterwards in_ready stays low while the counters are cleared, ovf_err is low, and the next build starts from an empty table.
- R8: While out_valid is high and out_ready is low, out_valid, out_key, out_pay and out_last hold their values.
- R9: After reset, out_valid, done and ovf_err are low, and in_ready stays low until the counter clearing has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Block can accept a row |
| in_key | input | KEY_W | Row key |
| in_pay | input | PAY_W | Row payload |
| in_last | input | 1 | Final row of the current table |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Consumer accepts the output row |
| out_key | output | KEY_W | Key of an unmatched probe row |
| out_pay | output | PAY_W | Payload of an unmatched probe row |
| out_last | output | 1 | Emitted row is the final probe row |
| done | output | 1 | One-cycle pulse at the end of the probe phase |
| ovf_err | output | 1 | Overflow pool exhausted; at least one build row was dropped |

## Verification
The bench runs three build/probe rounds.

The first round packs five keys into bucket 0, which fills the base slots and extends into the overflow chain. Its probe mixes hits in base slots, hits in the chain, and misses that must walk the whole chain. This separates a faulty base scan from a faulty chain walk.

The second round puts thirteen keys into one bucket, so the pool runs out. It shows that exactly the keys past capacity reappear as misses and that the error flag is raised. It also shows that keys left over from the first round no longer match once the counters have been cleared.

The third round ends its probe on a matching row. This checks that completion is still signalled without out_last. Output back-pressure follows a fixed pattern throughout, which exercises the output hold.

// File: rtl/hj_pkg.sv
package hj_pkg;
  typedef enum logic [3:0] {
    ST_CLR, ST_IN, ST_RD, ST_EVAL, ST_BRD, ST_BCMP,
    ST_ORD, ST_OCMP, ST_EMIT, ST_OUT, ST_END
  } hj_state_t;
endpackage

// File: rtl/hj_bank.sv
module hj_bank #(
  parameter int W  = 8,
  parameter int D  = 16,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hj_hash.sv
module hj_hash #(
  parameter int KEY_W    = 32,
  parameter int BKT_BITS = 8
) (
  input  logic                clk,
  input  logic                en,
  input  logic [KEY_W-1:0]    key,
  output logic [BKT_BITS-1:0] bkt
);
  localparam int NCH = (KEY_W + BKT_BITS - 1) / BKT_BITS;
  localparam int PADW = NCH * BKT_BITS;

  logic [PADW-1:0]     padded;
  logic [BKT_BITS-1:0] fold;

  assign padded = PADW'(key);

  always_comb begin
    fold = '0;
    for (int i = 0; i < NCH; i++) fold ^= padded[i*BKT_BITS +: BKT_BITS];
  end

  always_ff @(posedge clk) if (en) bkt <= fold;
endmodule

// File: rtl/hash_antijoin.sv
module hash_antijoin #(
  parameter int KEY_W      = 32,
  parameter int PAY_W      = 32,
  parameter int BKT_BITS   = 8,
  parameter int BASE_DEPTH = 3,
  parameter int OVF_DEPTH  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  input  logic [PAY_W-1:0] in_pay,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [PAY_W-1:0] out_pay,
  output logic             out_last,
  output logic             done,
  output logic             ovf_err
);
  import hj_pkg::*;

  localparam int NBKT = 1 << BKT_BITS;
  localparam int CBW  = $clog2(BASE_DEPTH + 1);
  localparam int OCW  = $clog2(OVF_DEPTH + 1);
  localparam int PTW  = $clog2(OVF_DEPTH);
  localparam int BAW  = $clog2(NBKT * BASE_DEPTH);

  hj_state_t st;
  logic                probe_ph;
  logic [KEY_W-1:0]    cur_key;
  logic [PAY_W-1:0]    cur_pay;
  logic                cur_last;
  logic [BKT_BITS-1:0] bkt, clr_idx, ctr_wa;
  logic [CBW-1:0]      idx, bcnt_rd, bcnt_wd;
  logic [OCW-1:0]      ocnt_rd, ocnt_wd, rem, free_q;
  logic [PTW-1:0]      ptr, head_rd, nxt_rd;
  logic [KEY_W-1:0]    base_rd, ovk_rd;
  logic [BAW-1:0]      base_wa, base_ra;
  logic clr, bld_eval, room_base, room_ovf, base_we, ovf_we, bcnt_we, ocnt_we;
  logic accept;

  assign in_ready = (st == ST_IN);
  assign accept   = in_valid && in_ready;

  hj_hash #(.KEY_W(KEY_W), .BKT_BITS(BKT_BITS)) u_hash (
    .clk(clk), .en(accept), .key(in_key), .bkt(bkt));

  assign clr       = (st == ST_CLR);
  assign bld_eval  = (st == ST_EVAL) && !probe_ph;
  assign room_base = bcnt_rd < CBW'(BASE_DEPTH);
  assign room_ovf  = free_q < OCW'(OVF_DEPTH);
  assign base_we   = bld_eval && room_base;
  assign ovf_we    = bld_eval && !room_base && room_ovf;
  assign bcnt_we   = clr || base_we;
  assign ocnt_we   = clr || ovf_we;
  assign ctr_wa    = clr ? clr_idx : bkt;
  assign bcnt_wd   = clr ? '0 : CBW'(bcnt_rd + 1'b1);
  assign ocnt_wd   = clr ? '0 : OCW'(ocnt_rd + 1'b1);
  assign base_wa   = BAW'(bkt) * BAW'(BASE_DEPTH) + BAW'(bcnt_rd);
  assign base_ra   = BAW'(bkt) * BAW'(BASE_DEPTH) + BAW'(idx);

  // per-bucket counters and chain heads
  hj_bank #(.W(CBW), .D(NBKT)) u_bcnt (.clk(clk), .we(bcnt_we), .waddr(ctr_wa),
    .wdata(bcnt_wd), .raddr(bkt), .rdata(bcnt_rd));
  hj_bank #(.W(OCW), .D(NBKT)) u_ocnt (.clk(clk), .we(ocnt_we), .waddr(ctr_wa),
    .wdata(ocnt_wd), .raddr(bkt), .rdata(ocnt_rd));
  hj_bank #(.W(PTW), .D(NBKT)) u_head (.clk(clk), .we(ovf_we), .waddr(bkt),
    .wdata(PTW'(free_q)), .raddr(bkt), .rdata(head_rd));
  // row banks: base slots and overflow chain
  hj_bank #(.W(KEY_W), .D(NBKT*BASE_DEPTH)) u_base (.clk(clk), .we(base_we),
    .waddr(base_wa), .wdata(cur_key), .raddr(base_ra), .rdata(base_rd));
  hj_bank #(.W(KEY_W), .D(OVF_DEPTH)) u_ovk (.clk(clk), .we(ovf_we),
    .waddr(PTW'(free_q)), .wdata(cur_key), .raddr(ptr), .rdata(ovk_rd));
  hj_bank #(.W(PTW), .D(OVF_DEPTH)) u_nxt (.clk(clk), .we(ovf_we),
    .waddr(PTW'(free_q)), .wdata(head_rd), .raddr(ptr), .rdata(nxt_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_CLR; probe_ph <= 1'b0; clr_idx <= '0; free_q <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; done <= 1'b0; ovf_err <= 1'b0;
      idx <= '0; ptr <= '0; rem <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_CLR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == BKT_BITS'(NBKT - 1)) begin
            st <= ST_IN; free_q <= '0;
          end
        end
        ST_IN: if (in_valid) begin
          cur_key <= in_key; cur_pay <= in_pay; cur_last <= in_last; st <= ST_RD;
        end
        ST_RD: st <= ST_EVAL;
        ST_EVAL: begin
          if (!probe_ph) begin
            if (!room_base) begin
              if (room_ovf) free_q <= free_q + 1'b1;
              else ovf_err <= 1'b1;
            end
            if (cur_last) probe_ph <= 1'b1;
            st <= ST_IN;
          end else begin
            idx <= '0; ptr <= head_rd; rem <= ocnt_rd;
            if (bcnt_rd != '0) st <= ST_BRD;
            else if (ocnt_rd != '0) st <= ST_ORD;
            else st <= ST_EMIT;
          end
        end
        ST_BRD: st <= ST_BCMP;
        ST_BCMP: begin
          if (base_rd == cur_key) st <= cur_last ? ST_END : ST_IN;
          else if (CBW'(idx + 1'b1) < bcnt_rd) begin
            idx <= idx + 1'b1; st <= ST_BRD;
          end else if (rem != '0) st <= ST_ORD;
          else st <= ST_EMIT;
        end
        ST_ORD: st <= ST_OCMP;
        ST_OCMP: begin
          if (ovk_rd == cur_key) st <= cur_last ? ST_END : ST_IN;
          else if (rem != OCW'(1)) begin
            rem <= rem - 1'b1; ptr <= nxt_rd; st <= ST_ORD;
          end else st <= ST_EMIT;
        end
        ST_EMIT: begin
          out_valid <= 1'b1; out_key <= cur_key; out_pay <= cur_pay;
          out_last <= cur_last; st <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          st <= out_last ? ST_END : ST_IN;
        end
        ST_END: begin
          done <= 1'b1; ovf_err <= 1'b0; probe_ph <= 1'b0;
          clr_idx <= '0; st <= ST_CLR;
        end
        default: st <= ST_CLR;
      endcase
    end
  end
endmodule

// File: rtl/hash_antijoin_chk.sv
module hash_antijoin_chk #(
  parameter int KEY_W = 32,
  parameter int PAY_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [KEY_W-1:0] out_key,
  input logic [PAY_W-1:0] out_pay,
  input logic             out_last,
  input logic             done,
  input logic             ovf_err,
  input logic             probe
);
  // R8: stalled output is frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_pay) && $stable(out_last));
  // R5: output only in probe phase
  a_r5_no_build_out: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> probe);
  // R7: completion lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: no input accepted while counters are being wiped
  a_r7_clear_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  // R4: error flag only drops at completion
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_err) |-> done);
  // R1: one row in flight, never taking input while presenting output
  a_r1_single_row: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

bind hash_antijoin hash_antijoin_chk #(.KEY_W(KEY_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_key(out_key), .out_pay(out_pay),
  .out_last(out_last), .done(done), .ovf_err(ovf_err), .probe(probe_ph));

// File: tb/hash_antijoin_tb.sv
module hash_antijoin_tb;
  localparam int BASE = 3, OVF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_key = '0, in_pay = '0;
  logic in_ready, out_valid, out_last, done, ovf_err;
  logic [31:0] out_key, out_pay;

  hash_antijoin u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_pay(in_pay), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key), .out_pay(out_pay), .out_last(out_last),
    .done(done), .ovf_err(ovf_err));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, done_cnt = 0, rec_n = 0;
  bit building = 1'b0, prev_stall = 1'b0;
  logic [31:0] prev_key;
  logic [31:0] rk [64];
  logic [31:0] rp [64];
  bit rl [64];
  logic [31:0] sm [32];
  logic [31:0] bg [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fold(input logic [31:0] k);
    return k[7:0] ^ k[15:8] ^ k[23:16] ^ k[31:24];
  endfunction

  // monitor: back-pressure, recording, stall hold, watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst) begin
      if (prev_stall) chk(out_valid && out_key == prev_key, "R8", out_key, prev_key);
      if (building) chk(!out_valid, "R5", 32'(out_valid), 32'd0);
      out_ready = (cyc % 4) != 1;
      if (out_valid && out_ready && rec_n < 64) begin
        rk[rec_n] = out_key; rp[rec_n] = out_pay; rl[rec_n] = out_last; rec_n++;
      end
      if (done) done_cnt++;
      prev_stall = out_valid && !out_ready;
      prev_key = out_key;
    end
  end

  task automatic send(input logic [31:0] k, input logic [31:0] p, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_key = k; in_pay = p; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_case(input int ns, input int nb, input int run_no);
    int bc [256];
    int ovu = 0, n_exp = 0;
    bit stored [32];
    bit exp_err = 1'b0;
    logic [31:0] ek [32];
    logic [31:0] ep [32];
    bit last_out;
    for (int i = 0; i < 256; i++) bc[i] = 0;
    for (int i = 0; i < ns; i++) begin
      int b = int'(fold(sm[i]));
      if (bc[b] < BASE) begin bc[b]++; stored[i] = 1'b1; end
      else if (ovu < OVF) begin ovu++; stored[i] = 1'b1; end
      else begin stored[i] = 1'b0; exp_err = 1'b1; end
    end
    for (int i = 0; i < nb; i++) begin
      bit hit = 1'b0;
      for (int j = 0; j < ns; j++) if (stored[j] && sm[j] == bg[i]) hit = 1'b1;
      if (!hit) begin ek[n_exp] = bg[i]; ep[n_exp] = bg[i] ^ 32'h5A5A_0000 ^ 32'(i); n_exp++; end
    end
    last_out = (n_exp > 0) && (ek[n_exp-1] == bg[nb-1]);
    building = 1'b1;
    for (int i = 0; i < ns; i++) send(sm[i], 32'hC0DE_0000 + 32'(i), i == ns - 1);
    repeat (6) @(negedge clk);
    building = 1'b0;
    chk(ovf_err == exp_err, "R4 error flag", 32'(ovf_err), 32'(exp_err));
    rec_n = 0;
    for (int i = 0; i < nb; i++) send(bg[i], bg[i] ^ 32'h5A5A_0000 ^ 32'(i), i == nb - 1);
    for (int t = 0; t < 2000 && done_cnt < run_no; t++) @(negedge clk);
    chk(done_cnt == run_no, "R7 done count", 32'(done_cnt), 32'(run_no));
    chk(rec_n == n_exp, "R1 output count", 32'(rec_n), 32'(n_exp));
    for (int i = 0; i < n_exp && i < rec_n; i++) begin
      chk(rk[i] == ek[i], "R1/R3 key", rk[i], ek[i]);
      chk(rp[i] == ep[i], "R1 payload", rp[i], ep[i]);
      chk(rl[i] == (last_out && i == n_exp - 1), "R6 last flag", 32'(rl[i]),
          32'(last_out && i == n_exp - 1));
    end
    @(negedge clk);
    chk(!in_ready && !ovf_err, "R7 clearing", {30'd0, in_ready, ovf_err}, 32'd0);
    for (int t = 0; t < 1000 && !in_ready; t++) @(negedge clk);
    chk(in_ready, "R7 ready after clear", 32'(in_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !ovf_err, "R9 reset outputs", {29'd0, out_valid, done, ovf_err}, 32'd0);
    chk(!in_ready, "R9 clearing after reset", 32'(in_ready), 32'd0);
    for (int t = 0; t < 1000 && !in_ready; t++) @(negedge clk);
    chk(in_ready, "R9 ready", 32'(in_ready), 32'd1);

    // run 1: bucket 0 spills two keys into the chain (R2, R3)
    for (int n = 1; n <= 5; n++) sm[n-1] = 32'h0000_0101 * 32'(n);
    sm[5] = 32'h11; sm[6] = 32'h22; sm[7] = 32'h1234_5678;
    bg[0] = 32'h0303; bg[1] = 32'h0606; bg[2] = 32'h11; bg[3] = 32'h33;
    bg[4] = 32'h0505; bg[5] = 32'h1234_5678; bg[6] = 32'h0101; bg[7] = 32'h0707;
    bg[8] = 32'h0202_0000; bg[9] = 32'h0404; bg[10] = 32'h99;
    run_case(8, 11, 1);

    // run 2: pool exhausted, two keys dropped (R4); earlier keys gone (R7)
    for (int n = 1; n <= 13; n++) sm[n-1] = 32'h0000_0101 * 32'(n);
    for (int n = 1; n <= 14; n++) bg[n-1] = 32'h0000_0101 * 32'(n);
    bg[14] = 32'h11; bg[15] = 32'h1234_5678; bg[16] = 32'h0d0d;
    run_case(13, 17, 2);

    // run 3: final probe row matches, no out_last (R6)
    sm[0] = 32'h77;
    bg[0] = 32'h88; bg[1] = 32'h77;
    run_case(1, 2, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule